// File: doc/BRIEF.md
# Stack-Depth Driven Shared Cache Model

This block stands in for a shared set-associative cache inside a fast statistical performance model. It never sees full addresses. Each request arrives already annotated with locality information: the requesting program's ID, the set index the access would use in the largest cache under study, the LRU stack depth the access had in that cache, the ID of the trace instruction making it, and a store flag. From that, the block decides hit or miss, keeps the per-set recency order, and warms itself up through per-line cold bits. It also reports when a miss pushes out a dirty line.

A second request type models a write-back arriving from an upper-level data cache. Its hit test is based on the instruction ID rather than on stack depth.

Each request is processed in a fixed two-cycle read-modify-write. The simulated cache may have fewer sets than the largest cache of interest. In that case, lines from several large-cache sets compete for one simulated set and are told apart by the full set index stored with each line.

Top module: `stackdepth_cache`

## Requirements
- R1: The simulated set is the low log2(SETS) bits of `req_sidx`. Every line keeps the full request set index and program ID it was filled with. An access only counts a line as its own when both fields match.
- R2: A normal access (`req_wb`=0) hits when its simulated set holds at least `req_depth` valid lines whose stored set index equals `req_sidx` and whose program ID equals `req_pid`. The touched line is the `req_depth`-th most recent of those lines. A depth of 0 is treated as depth 1.
- R3: A normal access with `req_depth` greater than WAYS always misses, even in a fully matching set. So does an access whose depth exceeds the number of matching lines by one.
- R4: The touched line becomes most recently used. On a miss, the least recently used line of the set is replaced and refilled with the request's program ID, set index and instruction ID.
- R5: After reset every line is cold and invalid. An access that fails its hit test while the set's LRU line is cold is reported as a hit (`rsp_hit`=1). That line is filled and its cold bit cleared, so later accesses that find no cold line miss.
- R6: A write-back request (`req_wb`=1) ignores `req_depth`. It hits when the set holds a valid line of the same program whose instruction ID is less than or equal to `req_iid`. It misses when no such line exists, including when every same-program line has a larger ID.
- R7: With WRITE_BACK=1, a store (`req_write`=1) or a write-back marks the touched line dirty, and a hit on a dirty line keeps it dirty. A miss that replaces a valid dirty line raises `rsp_dirty_evict`=1 with `rsp_hit`=0. Clean or cold victims leave `rsp_dirty_evict`=0.
- R8: `req_ready` is 1 when idle. A request is taken on a clock edge with `req_valid` and `req_ready` both 1. `req_ready` is then 0 for one cycle. After the next edge, `rsp_valid` is 1 for exactly one cycle, together with `rsp_hit` and `rsp_dirty_evict`.
- R9: While reset is held, and in the first idle cycle after it, `req_ready`=1 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_pid | input | PID_W | Requesting program ID |
| req_sidx | input | SIDX_W | Set index in the largest cache of interest |
| req_depth | input | DEPTH_W | LRU stack depth of the access (unused for write-backs) |
| req_iid | input | IID_W | Trace instruction ID of the access |
| req_write | input | 1 | Access is a store |
| req_wb | input | 1 | Request is a write-back from an upper-level cache |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_hit | output | 1 | Result is a hit (including a hit on a cold line) |
| rsp_dirty_evict | output | 1 | Miss replaced a dirty line |

## Verification
The hardest situation to reach from the ports is a dirty eviction in a fully warm set. It needs a store to a line, then enough misses from other program or set-index pairs to walk that line down to the LRU position, with no hit in between that pulls it back up. Write-back misses are hard for a similar reason: every same-program line in the set must carry a larger instruction ID than the request. A directed sequence builds both cases step by step in one simulated set. It uses aliasing set indices and rising depth values so that each step lands in a known recency order. Seeded random traffic then draws from a small pool of programs and set indices, so that matches, aliasing and evictions recur often, and every response is compared against a list-ordered model kept in the bench.

// File: rtl/shc_pkg.sv
package shc_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_UPDATE = 1'b1
  } shc_state_e;
endpackage

// File: rtl/shc_way_cmp.sv
// Per-way tag comparison: stack-depth match and write-back qualification.
module shc_way_cmp #(
  parameter int PID_W  = 4,
  parameter int SIDX_W = 8,
  parameter int IID_W  = 16
) (
  input  logic              valid,
  input  logic [PID_W-1:0]  pid,
  input  logic [SIDX_W-1:0] sidx,
  input  logic [IID_W-1:0]  iid,
  input  logic [PID_W-1:0]  req_pid,
  input  logic [SIDX_W-1:0] req_sidx,
  input  logic [IID_W-1:0]  req_iid,
  output logic              stack_match,
  output logic              wb_qual
);
  logic same_prog;

  always_comb begin
    same_prog   = valid && (pid == req_pid);
    stack_match = same_prog && (sidx == req_sidx);
    wb_qual     = same_prog && (iid <= req_iid);
  end
endmodule

// File: rtl/shc_set_eval.sv
// Evaluates one set: hit decision, touched way, victim and eviction state.
module shc_set_eval #(
  parameter int WAYS    = 4,
  parameter int PID_W   = 4,
  parameter int SIDX_W  = 8,
  parameter int IID_W   = 16,
  parameter int DEPTH_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic [WAYS-1:0]          line_valid,
  input  logic [WAYS-1:0]          line_cold,
  input  logic [WAYS-1:0]          line_dirty,
  input  logic [PID_W-1:0]         line_pid  [WAYS],
  input  logic [SIDX_W-1:0]        line_sidx [WAYS],
  input  logic [IID_W-1:0]         line_iid  [WAYS],
  input  logic [$clog2(WAYS)-1:0]  line_age  [WAYS],
  input  logic [PID_W-1:0]         req_pid,
  input  logic [SIDX_W-1:0]        req_sidx,
  input  logic [IID_W-1:0]         req_iid,
  input  logic [DEPTH_W-1:0]       req_depth,
  input  logic                     req_is_wb,
  output logic                     stack_hit,
  output logic                     hit,
  output logic                     dirty_evict,
  output logic [$clog2(WAYS)-1:0]  touch_way
);
  localparam int AGE_W = $clog2(WAYS);
  localparam int CNT_W = $clog2(WAYS + 1);

  logic [WAYS-1:0]    stack_m;
  logic [WAYS-1:0]    wb_q;
  logic [WAYS-1:0]    sel;
  logic [WAYS-1:0]    at_rank;
  logic [WAYS-1:0]    lru;
  logic [CNT_W-1:0]   match_cnt;
  logic [CNT_W-1:0]   rank [WAYS];
  logic [DEPTH_W-1:0] eff_depth;
  logic [DEPTH_W-1:0] target_rank;
  logic [AGE_W-1:0]   hit_way;
  logic [AGE_W-1:0]   victim_way;
  logic               victim_cold;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    shc_way_cmp #(.PID_W(PID_W), .SIDX_W(SIDX_W), .IID_W(IID_W)) u_cmp (
      .valid      (line_valid[w]),
      .pid        (line_pid[w]),
      .sidx       (line_sidx[w]),
      .iid        (line_iid[w]),
      .req_pid    (req_pid),
      .req_sidx   (req_sidx),
      .req_iid    (req_iid),
      .stack_match(stack_m[w]),
      .wb_qual    (wb_q[w])
    );

    // rank = number of selected lines more recent than this one
    always_comb begin
      rank[w] = '0;
      for (int v = 0; v < WAYS; v++) begin
        if (sel[v] && (line_age[v] < line_age[w])) rank[w] = rank[w] + CNT_W'(1);
      end
    end

    always_comb begin
      at_rank[w] = sel[w] && (DEPTH_W'(rank[w]) == target_rank);
      lru[w]     = (line_age[w] == AGE_W'(WAYS - 1));
    end
  end

  always_comb begin
    sel         = req_is_wb ? wb_q : stack_m;
    eff_depth   = (req_depth == '0) ? DEPTH_W'(1) : req_depth;
    target_rank = req_is_wb ? '0 : (eff_depth - DEPTH_W'(1));
    match_cnt   = '0;
    for (int w = 0; w < WAYS; w++) match_cnt = match_cnt + CNT_W'(stack_m[w]);
    stack_hit   = req_is_wb ? (|wb_q) : (DEPTH_W'(match_cnt) >= eff_depth);
  end

  always_comb begin
    hit_way    = '0;
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (at_rank[w]) hit_way    = AGE_W'(w);
      if (lru[w])     victim_way = AGE_W'(w);
    end
    victim_cold = |(lru & line_cold);
    hit         = stack_hit || victim_cold;
    dirty_evict = !stack_hit && !victim_cold && (|(lru & line_valid & line_dirty));
    touch_way   = stack_hit ? hit_way : victim_way;
  end

  // R3: a depth beyond the associativity can never find enough lines
  p_deep_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !req_is_wb && (req_depth > DEPTH_W'(WAYS))) |-> !stack_hit);

  // R5: a line is never both cold and valid
  p_cold_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ((line_cold & line_valid) == '0));

  // R4: the recency order of the set has exactly one oldest line
  p_single_lru_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(lru) == 1));
endmodule

// File: rtl/shc_age_update.sv
// Recency update: the touched way becomes age 0, younger ways age by one.
module shc_age_update #(
  parameter int WAYS = 4
) (
  input  logic [$clog2(WAYS)-1:0] age_in  [WAYS],
  input  logic [$clog2(WAYS)-1:0] touch_way,
  output logic [$clog2(WAYS)-1:0] age_out [WAYS]
);
  localparam int AGE_W = $clog2(WAYS);

  logic [AGE_W-1:0] touch_age;

  always_comb touch_age = age_in[touch_way];

  for (genvar w = 0; w < WAYS; w++) begin : g_age
    always_comb begin
      if (AGE_W'(w) == touch_way)       age_out[w] = '0;
      else if (age_in[w] < touch_age)   age_out[w] = age_in[w] + AGE_W'(1);
      else                              age_out[w] = age_in[w];
    end
  end
endmodule

// File: rtl/stackdepth_cache.sv
module stackdepth_cache
  import shc_pkg::*;
#(
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int PID_W      = 4,
  parameter int SIDX_W     = 8,
  parameter int IID_W      = 16,
  parameter bit WRITE_BACK = 1'b1,
  parameter int DEPTH_W    = $clog2(WAYS + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PID_W-1:0]   req_pid,
  input  logic [SIDX_W-1:0]  req_sidx,
  input  logic [DEPTH_W-1:0] req_depth,
  input  logic [IID_W-1:0]   req_iid,
  input  logic               req_write,
  input  logic               req_wb,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_dirty_evict
);
  localparam int SET_W = $clog2(SETS);
  localparam int AGE_W = $clog2(WAYS);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // line state
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   cold_q  [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [AGE_W-1:0]  age_q   [SETS][WAYS];
  logic [PID_W-1:0]  pid_q   [SETS][WAYS];
  logic [SIDX_W-1:0] sidx_q  [SETS][WAYS];
  logic [IID_W-1:0]  iid_q   [SETS][WAYS];

  // captured request
  logic [PID_W-1:0]   r_pid;
  logic [SIDX_W-1:0]  r_sidx;
  logic [DEPTH_W-1:0] r_depth;
  logic [IID_W-1:0]   r_iid;
  logic               r_write;
  logic               r_wb;

  shc_state_e state_q, state_d;
  logic       accept;
  logic       upd_en;
  logic [SET_W-1:0] cur_set;

  logic             stack_hit;
  logic             eval_hit;
  logic             eval_dirty_evict;
  logic [AGE_W-1:0] touch_way;
  logic [AGE_W-1:0] age_next [WAYS];
  logic             dirty_new;

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    accept    = req_valid && req_ready;
    upd_en    = (state_q == ST_UPDATE);
    cur_set   = r_sidx[SET_W-1:0];
    state_d   = state_q;
    case (state_q)
      ST_IDLE:   if (accept) state_d = ST_UPDATE;
      ST_UPDATE: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      r_pid   <= req_pid;
      r_sidx  <= req_sidx;
      r_depth <= req_depth;
      r_iid   <= req_iid;
      r_write <= req_write;
      r_wb    <= req_wb;
    end
  end

  shc_set_eval #(
    .WAYS(WAYS), .PID_W(PID_W), .SIDX_W(SIDX_W), .IID_W(IID_W), .DEPTH_W(DEPTH_W)
  ) u_eval (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .en         (upd_en),
    .line_valid (valid_q[cur_set]),
    .line_cold  (cold_q[cur_set]),
    .line_dirty (dirty_q[cur_set]),
    .line_pid   (pid_q[cur_set]),
    .line_sidx  (sidx_q[cur_set]),
    .line_iid   (iid_q[cur_set]),
    .line_age   (age_q[cur_set]),
    .req_pid    (r_pid),
    .req_sidx   (r_sidx),
    .req_iid    (r_iid),
    .req_depth  (r_depth),
    .req_is_wb  (r_wb),
    .stack_hit  (stack_hit),
    .hit        (eval_hit),
    .dirty_evict(eval_dirty_evict),
    .touch_way  (touch_way)
  );

  shc_age_update #(.WAYS(WAYS)) u_age (
    .age_in   (age_q[cur_set]),
    .touch_way(touch_way),
    .age_out  (age_next)
  );

  always_comb begin
    dirty_new = (stack_hit && dirty_q[cur_set][touch_way]) ||
                (WRITE_BACK && (r_write || r_wb));
  end

  // control bits of every line: reset to cold, invalid, clean, ordered ages
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        cold_q[s]  <= '1;
        dirty_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) age_q[s][w] <= AGE_W'(w);
      end
    end else if (upd_en) begin
      valid_q[cur_set][touch_way] <= 1'b1;
      cold_q[cur_set][touch_way]  <= 1'b0;
      dirty_q[cur_set][touch_way] <= dirty_new;
      for (int w = 0; w < WAYS; w++) age_q[cur_set][w] <= age_next[w];
    end
  end

  // tag fields carry no reset; valid_q qualifies them
  always_ff @(posedge clk) begin
    if (upd_en) begin
      pid_q[cur_set][touch_way]  <= r_pid;
      sidx_q[cur_set][touch_way] <= r_sidx;
      iid_q[cur_set][touch_way]  <= r_iid;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rsp_valid       <= 1'b0;
      rsp_hit         <= 1'b0;
      rsp_dirty_evict <= 1'b0;
    end else begin
      rsp_valid <= upd_en;
      if (upd_en) begin
        rsp_hit         <= eval_hit;
        rsp_dirty_evict <= eval_dirty_evict;
      end
    end
  end

  // R8: a taken request makes the block busy in the next cycle
  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    accept |=> !req_ready);

  // R8: the result strobe follows one cycle after the busy cycle
  p_rsp_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    accept |=> ##1 rsp_valid);

  // R7: a dirty eviction only ever accompanies a miss
  p_evict_on_miss_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rsp_valid && rsp_dirty_evict) |-> !rsp_hit);

  // R4: the line touched by the last update is most recently used afterwards
  p_touched_is_mru_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    rsp_valid |-> (age_q[$past(cur_set)][$past(touch_way)] == '0));
endmodule

// File: tb/stackdepth_cache_bench.sv
module stackdepth_cache_bench;
  localparam int SETS   = 4;
  localparam int WAYS   = 4;
  localparam int PID_W  = 2;
  localparam int SIDX_W = 4;
  localparam int IID_W  = 8;
  localparam int DEPTH_W = $clog2(WAYS + 2);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [PID_W-1:0]   req_pid = '0;
  logic [SIDX_W-1:0]  req_sidx = '0;
  logic [DEPTH_W-1:0] req_depth = '0;
  logic [IID_W-1:0]   req_iid = '0;
  logic req_write = 1'b0;
  logic req_wb = 1'b0;
  logic rsp_valid, rsp_hit, rsp_dirty_evict;

  always #4 clk = ~clk;

  stackdepth_cache #(
    .SETS(SETS), .WAYS(WAYS), .PID_W(PID_W), .SIDX_W(SIDX_W), .IID_W(IID_W),
    .WRITE_BACK(1'b1), .DEPTH_W(DEPTH_W)
  ) u_stackdepth_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pid(req_pid), .req_sidx(req_sidx), .req_depth(req_depth),
    .req_iid(req_iid), .req_write(req_write), .req_wb(req_wb),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_dirty_evict(rsp_dirty_evict)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // reference model: each set is a list ordered most recent first
  bit         m_valid [SETS][WAYS];
  bit         m_cold  [SETS][WAYS];
  bit         m_dirty [SETS][WAYS];
  int         m_pid   [SETS][WAYS];
  int         m_sidx  [SETS][WAYS];
  int         m_iid   [SETS][WAYS];

  task automatic model_reset();
    for (int s = 0; s < SETS; s++)
      for (int p = 0; p < WAYS; p++) begin
        m_valid[s][p] = 0; m_cold[s][p] = 1; m_dirty[s][p] = 0;
        m_pid[s][p] = 0; m_sidx[s][p] = 0; m_iid[s][p] = 0;
      end
  endtask

  task automatic model_access(input int pid, input int sidx, input int depth,
                              input int iid, input bit wr, input bit wb,
                              output bit hit, output bit dev);
    int s, pos, cnt, deff;
    bit shit, nd;
    s = sidx % SETS;
    pos = -1; cnt = 0;
    deff = (depth == 0) ? 1 : depth;
    for (int p = 0; p < WAYS; p++) begin
      if (wb) begin
        if (pos < 0 && m_valid[s][p] && m_pid[s][p] == pid && m_iid[s][p] <= iid) pos = p;
      end else if (m_valid[s][p] && m_pid[s][p] == pid && m_sidx[s][p] == sidx) begin
        cnt++;
        if (cnt == deff) pos = p;
      end
    end
    shit = (pos >= 0);
    dev = 0;
    if (shit) hit = 1;
    else begin
      pos = WAYS - 1;
      hit = m_cold[s][pos];
      dev = !m_cold[s][pos] && m_valid[s][pos] && m_dirty[s][pos];
    end
    nd = (shit && m_dirty[s][pos]) || wr || wb;
    for (int p = pos; p > 0; p--) begin
      m_valid[s][p] = m_valid[s][p-1]; m_cold[s][p] = m_cold[s][p-1];
      m_dirty[s][p] = m_dirty[s][p-1]; m_pid[s][p] = m_pid[s][p-1];
      m_sidx[s][p] = m_sidx[s][p-1];   m_iid[s][p] = m_iid[s][p-1];
    end
    m_valid[s][0] = 1; m_cold[s][0] = 0; m_dirty[s][0] = nd;
    m_pid[s][0] = pid; m_sidx[s][0] = sidx; m_iid[s][0] = iid;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one request; directed calls pass fixed expectations, random ones use the model
  task automatic access(input int pid, input int sidx, input int depth, input int iid,
                        input bit wr, input bit wb, input bit use_exp,
                        input bit exp_hit, input bit exp_dev, input bit chk_hs,
                        input string req);
    bit mh, md, eh, ed;
    model_access(pid, sidx, depth, iid, wr, wb, mh, md);
    eh = use_exp ? exp_hit : mh;
    ed = use_exp ? exp_dev : md;
    @(negedge clk);
    if (chk_hs) check(req_ready == 1'b1, "R8", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    req_pid = PID_W'(pid); req_sidx = SIDX_W'(sidx); req_depth = DEPTH_W'(depth);
    req_iid = IID_W'(iid); req_write = wr; req_wb = wb;
    @(negedge clk);
    req_valid = 1'b0;
    if (chk_hs) begin
      check(req_ready == 1'b0, "R8", "ready in busy cycle", int'(req_ready), 0);
      check(rsp_valid == 1'b0, "R8", "no early result", int'(rsp_valid), 0);
    end
    @(negedge clk);
    check(rsp_valid == 1'b1, "R8", "result strobe", int'(rsp_valid), 1);
    check(rsp_hit == eh, req, "rsp_hit", int'(rsp_hit), int'(eh));
    check(rsp_dirty_evict == ed, req, "rsp_dirty_evict", int'(rsp_dirty_evict), int'(ed));
    if (use_exp) check(mh == exp_hit && md == exp_dev, req, "model agreement",
                       int'({mh, md}), int'({exp_hit, exp_dev}));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    model_reset();
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9", "ready in reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R9", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R9", "ready after reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R9", "rsp_valid after reset", int'(rsp_valid), 0);

    // directed walk through simulated set 0 (sidx 0, 4, 8, 12 alias)
    access(1, 0, 1, 10, 1, 0, 1, 1, 0, 1, "R5");   // cold hit, store
    access(1, 0, 1, 11, 0, 0, 1, 1, 0, 1, "R2");   // true stack hit
    access(2, 4, 1, 20, 0, 0, 1, 1, 0, 1, "R5");   // cold fill
    access(2, 8, 1, 21, 0, 0, 1, 1, 0, 0, "R5");
    access(3, 0, 1, 30, 0, 0, 1, 1, 0, 0, "R5");   // set now warm
    access(1, 4, 1, 40, 0, 0, 1, 0, 1, 0, "R1");   // aliasing index misses, dirty LRU out (R7, R4)
    access(2, 4, 5, 50, 0, 0, 1, 0, 0, 0, "R3");   // depth above WAYS
    access(2, 4, 1, 51, 0, 0, 1, 1, 0, 0, "R2");
    access(2, 0, 0, 5, 0, 1, 1, 0, 0, 0, "R6");    // all same-program IDs larger
    access(2, 0, 0, 30, 0, 1, 1, 1, 0, 0, "R6");   // write-back hit
    access(3, 0, 1, 60, 1, 0, 1, 1, 0, 0, "R7");   // store on hit
    access(0, 12, 1, 70, 0, 0, 1, 0, 0, 0, "R4");
    access(0, 12, 2, 71, 0, 0, 1, 0, 0, 0, "R3");  // one match, depth 2
    access(0, 12, 3, 72, 0, 0, 1, 0, 1, 0, "R7");  // dirty write-back line evicted
    access(0, 12, 3, 73, 0, 0, 1, 1, 0, 0, "R2");  // three matches, depth 3
    access(0, 12, 0, 74, 0, 0, 1, 1, 0, 0, "R2");  // depth 0 as 1
    access(0, 12, 4, 75, 0, 0, 1, 0, 1, 0, "R3");  // three matches, depth 4; dirty victim (R7)
    access(1, 1, 1, 80, 0, 0, 1, 1, 0, 1, "R1");   // other simulated set still cold

    // seeded random traffic against the model
    void'($urandom(32'd2024));
    for (int i = 0; i < 5000; i++) begin
      int pid, sidx, depth, iid;
      bit wr, wb;
      pid   = int'($urandom_range(0, 2));
      sidx  = int'($urandom_range(0, 9));
      depth = int'($urandom_range(0, WAYS + 1));
      iid   = int'($urandom_range(0, 255));
      wr    = ($urandom_range(0, 3) == 0);
      wb    = ($urandom_range(0, 4) == 0);
      access(pid, sidx, depth, iid, wr, wb, 0, 0, 0, (i % 500) == 0,
             wb ? "R6" : "R2");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule